// File: doc/BRIEF.md
# Auxiliary Memory Bank Selector

This block sits beside the CPU bus of an 8-bit machine with a 64K address space and a second 64K RAM bank. It holds a set of one-bit mode flags called soft switches. The CPU changes a flag by touching a switch address, and can read any flag back as a status byte. For every CPU access the block reports two things: which RAM region the address falls in, and whether that access is steered to the auxiliary bank or to the main bank.

There are three steered regions: zero page with the stack, the general RAM area, and the text page. The text page can be tied to the display page flag instead of the separate read and write bank flags. This lets display software flip the text page between banks with one switch.

The bank select and region outputs are combinational from the current address, the access direction and the flag state. Flag changes are registered.

Top module: `aux_bank_sel`

## Requirements
- R1: A write to $C000–$C00F updates one flag, chosen by address bits [3:1]: 0 store-mode, 1 read-aux, 2 write-aux, 3 slot-rom, 4 alt-zero-page, 5 slot3-rom, 6 wide-column, 7 alt-charset. Address bit 0 is the new value (odd sets, even clears). Reads of $C000–$C00F change no flag.
- R2: The slot-rom flag has inverted polarity. A write to $C006 sets it and a write to $C007 clears it.
- R3: Any read or write to $C050–$C057 updates one display flag, chosen by address bits [2:1]: 0 text, 1 mixed, 2 page-2, 3 hi-res. Address bit 0 is the new value.
- R4: A read of $C013–$C01F raises `stat_hit_o` and returns the flag in bit 7, with bits 6:0 zero. The addresses from $C013 upward return, in order: read-aux, write-aux, slot-rom, alt-zero-page, slot3-rom, store-mode, `vbl_i`, text, mixed, page-2, hi-res, alt-charset, wide-column. A write to those addresses gives no hit and changes no flag.
- R5: Region code 1 covers $0000–$01FF. In that region, `ram_aux_o` equals alt-zero-page for both reads and writes.
- R6: Region code 2 covers $0200–$BFFF outside the text page, including $2000–$3FFF. In that region, reads follow read-aux and writes follow write-aux, and store-mode has no effect.
- R7: Region code 3 covers $0400–$07FF. With store-mode set, page-2 selects the bank for both directions. With store-mode clear, reads follow read-aux and writes follow write-aux.
- R8: Reset clears every flag.
- R9: A flag changes only at the clock edge that ends a valid switch access, and it is seen from the next bus cycle. Addresses at $C000 and above report region 0 and `ram_aux_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | A CPU access is present this cycle |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 16 | CPU address |
| vbl_i | input | 1 | Vertical blank level, reported by status read |
| ram_region_o | output | 2 | 0 none, 1 zero page/stack, 2 general, 3 text page |
| ram_aux_o | output | 1 | 1 when the access goes to the auxiliary bank |
| stat_hit_o | output | 1 | Status read in progress |
| stat_data_o | output | 8 | Status byte, flag in bit 7 |

## Verification
The region, bank select and status outputs carry no register, so the bench samples them in the same cycle as the address, one nanosecond after driving at the falling edge. A flag change is due one rising edge after its switch access. The vector table therefore places the access that depends on a flag directly after the switch access, and checks it in the following cycle. Reset is checked by status reads and bank selects taken right after reset is released. The idle-hold rule is checked by holding switch addresses with the valid input low and then reading the flags back.

// File: rtl/aux_bank_pkg.sv
package aux_bank_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ZP_LAST   = 16'h01FF;
  localparam logic [ADDR_W-1:0] TXT_FIRST = 16'h0400;
  localparam logic [ADDR_W-1:0] TXT_LAST  = 16'h07FF;
  localparam logic [ADDR_W-1:0] RAM_LAST  = 16'hBFFF;

  localparam logic [ADDR_W-5:0] SW_PAGE   = 12'hC00;
  localparam logic [ADDR_W-5:0] STAT_PAGE = 12'hC01;
  localparam logic [ADDR_W-4:0] DISP_PAGE = 13'h180A;

  typedef struct packed {
    logic store80;
    logic ramrd;
    logic ramwrt;
    logic cxrom;
    logic altzp;
    logic c3rom;
    logic col80;
    logic altchar;
    logic text;
    logic mixed;
    logic page2;
    logic hires;
  } sw_flags_t;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_ZP   = 2'd1,
    REG_GEN  = 2'd2,
    REG_TEXT = 2'd3
  } region_e;
endpackage

// File: rtl/aux_sw_regs.sv
module aux_sw_regs
  import aux_bank_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output sw_flags_t     flags_o
);
  sw_flags_t flags_q;
  logic      sw_wr, disp_acc, val;

  assign sw_wr    = valid_i && we_i && (addr_i[AW-1:4] == SW_PAGE);
  assign disp_acc = valid_i && (addr_i[AW-1:3] == DISP_PAGE);
  assign val      = addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else begin
      if (sw_wr) begin
        case (addr_i[3:1])
          3'd0: flags_q.store80 <= val;
          3'd1: flags_q.ramrd   <= val;
          3'd2: flags_q.ramwrt  <= val;
          3'd3: flags_q.cxrom   <= ~val;  // inverted pair
          3'd4: flags_q.altzp   <= val;
          3'd5: flags_q.c3rom   <= val;
          3'd6: flags_q.col80   <= val;
          default: flags_q.altchar <= val;
        endcase
      end
      if (disp_acc) begin
        case (addr_i[2:1])
          2'd0: flags_q.text  <= val;
          2'd1: flags_q.mixed <= val;
          2'd2: flags_q.page2 <= val;
          default: flags_q.hires <= val;
        endcase
      end
    end
  end

  assign flags_o = flags_q;

  a_r1_ramrd_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && we_i && addr_i == 16'hC003) |=> flags_q.ramrd);
  a_r1_read_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !we_i && addr_i[AW-1:4] == SW_PAGE) |=> $stable(flags_q));
  a_r2_cxrom_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && we_i && addr_i == 16'hC006) |=> flags_q.cxrom);
  a_r2_cxrom_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && we_i && addr_i == 16'hC007) |=> !flags_q.cxrom);
  a_r3_page2_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !we_i && addr_i == 16'hC055) |=> flags_q.page2);
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_q));
endmodule

// File: rtl/aux_region_decode.sv
module aux_region_decode
  import aux_bank_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  output region_e       region_o
);
  always_comb begin
    if (addr_i <= ZP_LAST)
      region_o = REG_ZP;
    else if (addr_i >= TXT_FIRST && addr_i <= TXT_LAST)
      region_o = REG_TEXT;
    else if (addr_i <= RAM_LAST)
      region_o = REG_GEN;
    else
      region_o = REG_NONE;
  end
endmodule

// File: rtl/aux_bank_steer.sv
module aux_bank_steer
  import aux_bank_pkg::*;
(
  input  region_e region_i,
  input  logic    we_i,
  input  logic    store80_i,
  input  logic    ramrd_i,
  input  logic    ramwrt_i,
  input  logic    altzp_i,
  input  logic    page2_i,
  output logic    aux_o
);
  logic rw_sel;
  assign rw_sel = we_i ? ramwrt_i : ramrd_i;

  always_comb begin
    unique case (region_i)
      REG_ZP:   aux_o = altzp_i;
      REG_GEN:  aux_o = rw_sel;
      REG_TEXT: aux_o = store80_i ? page2_i : rw_sel;
      default:  aux_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/aux_status_mux.sv
module aux_status_mux
  import aux_bank_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  sw_flags_t     flags_i,
  input  logic          vbl_i,
  output logic          hit_o,
  output logic [DW-1:0] data_o
);
  localparam int FLAG_BIT = DW - 1;
  logic bit_v;

  assign hit_o = valid_i && !we_i && (addr_i[AW-1:4] == STAT_PAGE) && (addr_i[3:0] >= 4'h3);

  always_comb begin
    case (addr_i[3:0])
      4'h3: bit_v = flags_i.ramrd;
      4'h4: bit_v = flags_i.ramwrt;
      4'h5: bit_v = flags_i.cxrom;
      4'h6: bit_v = flags_i.altzp;
      4'h7: bit_v = flags_i.c3rom;
      4'h8: bit_v = flags_i.store80;
      4'h9: bit_v = vbl_i;
      4'hA: bit_v = flags_i.text;
      4'hB: bit_v = flags_i.mixed;
      4'hC: bit_v = flags_i.page2;
      4'hD: bit_v = flags_i.hires;
      4'hE: bit_v = flags_i.altchar;
      4'hF: bit_v = flags_i.col80;
      default: bit_v = 1'b0;
    endcase
    data_o = '0;
    data_o[FLAG_BIT] = hit_o & bit_v;
  end

  a_r4_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> data_o[FLAG_BIT-1:0] == '0);
  a_r4_quiet_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (!hit_o && data_o == '0));
endmodule

// File: rtl/aux_bank_sel.sv
module aux_bank_sel
  import aux_bank_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_valid_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          vbl_i,
  output logic [1:0]    ram_region_o,
  output logic          ram_aux_o,
  output logic          stat_hit_o,
  output logic [DW-1:0] stat_data_o
);
  sw_flags_t flags;
  region_e   region;

  aux_sw_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .valid_i (bus_valid_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .flags_o (flags)
  );

  aux_region_decode #(.AW(AW)) u_dec (
    .addr_i   (bus_addr_i),
    .region_o (region)
  );

  aux_bank_steer u_steer (
    .region_i  (region),
    .we_i      (bus_we_i),
    .store80_i (flags.store80),
    .ramrd_i   (flags.ramrd),
    .ramwrt_i  (flags.ramwrt),
    .altzp_i   (flags.altzp),
    .page2_i   (flags.page2),
    .aux_o     (ram_aux_o)
  );

  aux_status_mux #(.AW(AW), .DW(DW)) u_stat (
    .clk_i, .rst_ni,
    .valid_i (bus_valid_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .flags_i (flags),
    .vbl_i,
    .hit_o   (stat_hit_o),
    .data_o  (stat_data_o)
  );

  assign ram_region_o = region;

  a_r5_zp_follows_altzp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region == REG_ZP) |-> (ram_aux_o == flags.altzp));
  a_r7_text_page2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region == REG_TEXT && flags.store80) |-> (ram_aux_o == flags.page2));
  a_r6_gen_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region == REG_GEN && bus_we_i) |-> (ram_aux_o == flags.ramwrt));
  a_r9_upper_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i > RAM_LAST) |-> (ram_region_o == 2'd0 && !ram_aux_o));
endmodule

// File: tb/sim_aux_bank_sel.sv
module sim_aux_bank_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        vbl = 1'b0;
  logic [1:0]  region;
  logic        aux;
  logic        hit;
  logic [7:0]  sdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  aux_bank_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_we_i(we),
    .bus_addr_i(addr), .vbl_i(vbl), .ram_region_o(region), .ram_aux_o(aux),
    .stat_hit_o(hit), .stat_data_o(sdata)
  );

  typedef struct packed {
    logic [15:0] a;
    logic        w;
    logic [1:0]  rg;
    logic        ax;
    logic        ht;
    logic [7:0]  d;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t TBL [0:NV-1] = '{
    '{16'h0100,1'b0,2'd1,1'b0,1'b0,8'h00,4'd8}, // R8 reset: main bank
    '{16'hC009,1'b1,2'd0,1'b0,1'b0,8'h00,4'd1}, // R1 alt-zp on
    '{16'h0100,1'b0,2'd1,1'b1,1'b0,8'h00,4'd5}, // R5
    '{16'h01FF,1'b1,2'd1,1'b1,1'b0,8'h00,4'd5}, // R5
    '{16'hC016,1'b0,2'd0,1'b0,1'b1,8'h80,4'd4}, // R4
    '{16'hC003,1'b1,2'd0,1'b0,1'b0,8'h00,4'd1}, // R1 read-aux on
    '{16'h0200,1'b0,2'd2,1'b1,1'b0,8'h00,4'd6}, // R6
    '{16'h0200,1'b1,2'd2,1'b0,1'b0,8'h00,4'd6}, // R6
    '{16'h0400,1'b0,2'd3,1'b1,1'b0,8'h00,4'd7}, // R7
    '{16'h07FF,1'b1,2'd3,1'b0,1'b0,8'h00,4'd7}, // R7
    '{16'hC005,1'b1,2'd0,1'b0,1'b0,8'h00,4'd1}, // R1 write-aux on
    '{16'h2000,1'b1,2'd2,1'b1,1'b0,8'h00,4'd6}, // R6
    '{16'hC001,1'b1,2'd0,1'b0,1'b0,8'h00,4'd1}, // R1 store on
    '{16'h0400,1'b0,2'd3,1'b0,1'b0,8'h00,4'd7}, // R7 page2=0
    '{16'hC055,1'b0,2'd0,1'b0,1'b0,8'h00,4'd3}, // R3 read sets page2
    '{16'h0400,1'b1,2'd3,1'b1,1'b0,8'h00,4'd7}, // R7
    '{16'hC002,1'b1,2'd0,1'b0,1'b0,8'h00,4'd1}, // R1 read-aux off
    '{16'h2000,1'b0,2'd2,1'b0,1'b0,8'h00,4'd6}, // R6 store ignored
    '{16'h0500,1'b0,2'd3,1'b1,1'b0,8'h00,4'd7}, // R7
    '{16'hC01C,1'b0,2'd0,1'b0,1'b1,8'h80,4'd3}, // R3
    '{16'hC018,1'b0,2'd0,1'b0,1'b1,8'h80,4'd4}, // R4
    '{16'hC013,1'b0,2'd0,1'b0,1'b1,8'h00,4'd4}, // R4
    '{16'hC006,1'b1,2'd0,1'b0,1'b0,8'h00,4'd2}, // R2
    '{16'hC015,1'b0,2'd0,1'b0,1'b1,8'h80,4'd2}, // R2
    '{16'hC007,1'b1,2'd0,1'b0,1'b0,8'h00,4'd2}, // R2
    '{16'hC015,1'b0,2'd0,1'b0,1'b1,8'h00,4'd2}, // R2
    '{16'hC000,1'b0,2'd0,1'b0,1'b0,8'h00,4'd1}, // R1 read ignored
    '{16'hC018,1'b0,2'd0,1'b0,1'b1,8'h80,4'd1}, // R1
    '{16'hC01A,1'b1,2'd0,1'b0,1'b0,8'h00,4'd4}, // R4 write no hit
    '{16'hC01A,1'b0,2'd0,1'b0,1'b1,8'h00,4'd4}, // R4
    '{16'hC000,1'b1,2'd0,1'b0,1'b0,8'h00,4'd1}, // R1 store off
    '{16'h0400,1'b0,2'd3,1'b0,1'b0,8'h00,4'd7}, // R7
    '{16'h0400,1'b1,2'd3,1'b1,1'b0,8'h00,4'd7}, // R7
    '{16'hC00F,1'b1,2'd0,1'b0,1'b0,8'h00,4'd1}, // R1
    '{16'hC01E,1'b0,2'd0,1'b0,1'b1,8'h80,4'd1}, // R1
    '{16'hC00D,1'b1,2'd0,1'b0,1'b0,8'h00,4'd1}, // R1
    '{16'hC01F,1'b0,2'd0,1'b0,1'b1,8'h80,4'd1}, // R1
    '{16'hC00B,1'b1,2'd0,1'b0,1'b0,8'h00,4'd1}, // R1
    '{16'hC017,1'b0,2'd0,1'b0,1'b1,8'h80,4'd1}, // R1
    '{16'hC051,1'b1,2'd0,1'b0,1'b0,8'h00,4'd3}, // R3
    '{16'hC01A,1'b0,2'd0,1'b0,1'b1,8'h80,4'd3}, // R3
    '{16'hC053,1'b0,2'd0,1'b0,1'b0,8'h00,4'd3}, // R3
    '{16'hC01B,1'b0,2'd0,1'b0,1'b1,8'h80,4'd3}, // R3
    '{16'hC057,1'b1,2'd0,1'b0,1'b0,8'h00,4'd3}, // R3
    '{16'hC01D,1'b0,2'd0,1'b0,1'b1,8'h80,4'd3}, // R3
    '{16'hC054,1'b1,2'd0,1'b0,1'b0,8'h00,4'd3}, // R3
    '{16'hC01C,1'b0,2'd0,1'b0,1'b1,8'h00,4'd3}, // R3
    '{16'hD000,1'b0,2'd0,1'b0,1'b0,8'h00,4'd9}, // R9 upper
    '{16'hC008,1'b1,2'd0,1'b0,1'b0,8'h00,4'd1}, // R1 alt-zp off
    '{16'h01FF,1'b1,2'd1,1'b0,1'b0,8'h00,4'd5}, // R5
    '{16'hBFFF,1'b1,2'd2,1'b1,1'b0,8'h00,4'd6}, // R6
    '{16'hC000,1'b0,2'd0,1'b0,1'b0,8'h00,4'd9}  // R9
  };

  task automatic chk(input int rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // drive at negedge, sample combinational outputs 1 ns later
  task automatic access(input logic [15:0] a, input logic w);
    @(negedge clk);
    valid = 1'b1; addr = a; we = w;
    #1;
  endtask

  task automatic idle;
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: every status reads zero after reset
    for (int s = 16'hC013; s <= 16'hC01F; s++) begin
      access(16'(s), 1'b0);
      chk(8, "reset status", sdata, 8'h00);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      access(TBL[i].a, TBL[i].w);
      chk(int'(TBL[i].rq), "region", region, TBL[i].rg);
      chk(int'(TBL[i].rq), "aux", aux, TBL[i].ax);
      chk(int'(TBL[i].rq), "hit", hit, TBL[i].ht);
      chk(int'(TBL[i].rq), "status", sdata, TBL[i].d);
    end

    // R4: vbl level reported
    vbl = 1'b1;
    access(16'hC019, 1'b0);
    chk(4, "vbl status", sdata, 8'h80);
    vbl = 1'b0;
    #1;
    chk(4, "vbl low", sdata, 8'h00);

    // R9: switch addresses with valid low do nothing
    idle;
    addr = 16'hC004; we = 1'b1;
    @(negedge clk); addr = 16'hC009;
    @(negedge clk); addr = 16'hC050; we = 1'b0;
    @(negedge clk);
    access(16'h2000, 1'b1);
    chk(9, "idle write-aux kept", aux, 1);
    access(16'h0000, 1'b0);
    chk(9, "idle alt-zp kept", aux, 0);
    access(16'hC01A, 1'b0);
    chk(9, "idle text kept", sdata, 8'h80);

    // R8: mid-run reset clears flags
    access(16'hC009, 1'b1);
    idle;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(16'h0000, 1'b1);
    chk(8, "reset alt-zp", aux, 0);
    access(16'h3000, 1'b1);
    chk(8, "reset write-aux", aux, 0);
    access(16'hC01A, 1'b0);
    chk(8, "reset text", sdata, 8'h00);
    idle;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule